// File: doc/BRIEF.md
# No-Load Creep Suppression Detector

This block sits between a power calculation stage and an energy accumulator. Each valid power sample is compared against a small threshold: a fraction of the full-scale magnitude, chosen by a 2-bit mode field. A sample below that threshold is kept out of the accumulator, so a meter with no real load does not slowly build up phantom energy. A fourth mode code switches detection off, and every sample then passes through unchanged.

A below-threshold sample also sets a sticky no-load status flag. An interrupt request is the flag qualified by an enable bit, and it stays raised until a clear strobe drops the flag. A select input can apply the same threshold test to a second, RMS-current sample path that feeds a pulse output. That second path never touches the status flag.

The gating style is chosen by a parameter. In the default style a blocked sample still emits a valid strobe, with its magnitude forced to zero. In the alternative style the valid strobe itself is suppressed. Full scale and sample width are parameters, and each threshold is derived from them at elaboration.

Top module: `nlc_detector`

## Requirements
- R1: With mode 00, every valid sample appears on the accumulation output one clock later with its magnitude unchanged, and the status flag is not set.
- R2: Mode codes 01, 10 and 11 select thresholds of floor(FULL_SCALE*3/10000), half of that, and a quarter of that, each rounded down. With the default FULL_SCALE of 8,000,000 these are 2400, 1200 and 600.
- R3: In any enabled mode, a valid sample below the selected threshold is blocked from accumulation. In the default zero style the output is valid with magnitude 0 one clock later. In the drop style the output valid stays low.
- R4: The comparison is strictly less-than. A sample equal to the threshold, or above it, passes unchanged.
- R5: A blocked power sample sets the status flag one clock later. The flag then holds its value until a clear strobe arrives.
- R6: A clear strobe drops the flag one clock later. If a blocked sample arrives in the same cycle as the clear strobe, the flag ends up set.
- R7: The interrupt request is high exactly while the flag is set and the interrupt enable is high.
- R8: When the RMS select is high, the RMS-current path applies the same threshold and gating rule. When the select is low, or the mode is 00, RMS samples pass unchanged. RMS samples never change the flag.
- R9: Each sample is judged against the mode present in its own valid cycle, so a mode change takes effect on the very next valid sample, including back-to-back samples.
- R10: During and after reset, both output valids are low, both magnitudes are 0, and the flag and interrupt request are low. A cycle with no valid input yields a low output valid one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Power sample valid strobe |
| smp_mag_i | input | PWR_W | Power sample magnitude |
| nl_mode_i | input | 2 | Threshold mode code |
| irq_en_i | input | 1 | Interrupt enable |
| stat_clr_i | input | 1 | Status flag clear strobe |
| irms_sel_i | input | 1 | Apply the threshold test to the RMS path |
| irms_vld_i | input | 1 | RMS-current sample valid |
| irms_mag_i | input | PWR_W | RMS-current sample magnitude |
| acc_vld_o | output | 1 | Gated sample valid toward the accumulator |
| acc_mag_o | output | PWR_W | Gated sample magnitude toward the accumulator |
| irms_vld_o | output | 1 | Gated RMS sample valid |
| irms_mag_o | output | PWR_W | Gated RMS sample magnitude |
| nl_flag_o | output | 1 | Sticky no-load status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Both gated sample outputs and the status flag come from a single register stage. Their value is therefore due one clock after the cycle in which the input or strobe was presented. The interrupt request follows the flag and the enable without any further register. The bench drives inputs on falling edges and samples every result on the next falling edge, exactly one rising edge later. It checks the interrupt in the same half-cycle as the enable change that affects it. Back-to-back samples and simultaneous set and clear are checked cycle by cycle to pin down which value each edge produces.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
   typedef enum logic [1:0] {
      NLC_OFF = 2'b00,
      NLC_HI  = 2'b01,
      NLC_MID = 2'b10,
      NLC_LO  = 2'b11
   } nlc_mode_e;

   localparam int NLC_LEVELS = 3;

   function automatic longint unsigned nlc_base_thr(input longint unsigned fs);
      return (fs * 3) / 10000;
   endfunction
endpackage

// File: rtl/nlc_thresh_sel.sv
module nlc_thresh_sel #(
   parameter int              PWR_W      = 24,
   parameter longint unsigned FULL_SCALE = 64'd8000000
) (
   input  logic [1:0]       mode_i,
   output logic [PWR_W-1:0] thr_o,
   output logic             det_en_o
);
   import nlc_pkg::*;

   localparam longint unsigned BASE = nlc_base_thr(FULL_SCALE);

   if (PWR_W < 2 || PWR_W > 62) begin : g_bad_width
      $error("nlc_thresh_sel: PWR_W out of range");
   end
   if (FULL_SCALE >= (64'd1 << PWR_W)) begin : g_bad_fs
      $error("nlc_thresh_sel: FULL_SCALE does not fit PWR_W");
   end
   if ((BASE >> (NLC_LEVELS - 1)) == 0) begin : g_bad_lo
      $error("nlc_thresh_sel: lowest threshold rounds to zero");
   end

   logic [PWR_W-1:0] lvl [NLC_LEVELS];

   for (genvar k = 0; k < NLC_LEVELS; k++) begin : g_lvl
      assign lvl[k] = PWR_W'(BASE >> k);
   end

   always_comb begin
      det_en_o = 1'b1;
      thr_o    = '0;
      unique case (nlc_mode_e'(mode_i))
         NLC_HI:  thr_o = lvl[0];
         NLC_MID: thr_o = lvl[1];
         NLC_LO:  thr_o = lvl[2];
         default: det_en_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/nlc_gate.sv
module nlc_gate #(
   parameter int PWR_W      = 24,
   parameter bit DROP_STYLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [PWR_W-1:0] mag_i,
   input  logic [PWR_W-1:0] thr_i,
   input  logic             det_en_i,
   output logic             vld_o,
   output logic [PWR_W-1:0] mag_o,
   output logic             below_o
);
   logic pass;

   assign below_o = vld_i && det_en_i && (mag_i < thr_i);
   assign pass    = vld_i && !below_o;

   if (DROP_STYLE) begin : g_drop
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_o <= 1'b0;
            mag_o <= '0;
         end else begin
            vld_o <= pass;
            mag_o <= pass ? mag_i : '0;
         end
      end

      assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_i && det_en_i && mag_i < thr_i) |=> !vld_o);
   end else begin : g_zero
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_o <= 1'b0;
            mag_o <= '0;
         end else begin
            vld_o <= vld_i;
            mag_o <= pass ? mag_i : '0;
         end
      end

      assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_i && det_en_i && mag_i < thr_i) |=> (vld_o && mag_o == '0));
   end

   assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !det_en_i) |=> (vld_o && mag_o == $past(mag_i)));

   assert_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && det_en_i && mag_i >= thr_i) |=> (vld_o && mag_o == $past(mag_i)));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !vld_o);
endmodule

// File: rtl/nlc_status.sv
module nlc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   assign irq_o = flag_o & irq_en_i;

   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/nlc_detector.sv
module nlc_detector #(
   parameter int              PWR_W      = 24,
   parameter longint unsigned FULL_SCALE = 64'd8000000,
   parameter bit              DROP_STYLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld_i,
   input  logic [PWR_W-1:0] smp_mag_i,
   input  logic [1:0]       nl_mode_i,
   input  logic             irq_en_i,
   input  logic             stat_clr_i,
   input  logic             irms_sel_i,
   input  logic             irms_vld_i,
   input  logic [PWR_W-1:0] irms_mag_i,
   output logic             acc_vld_o,
   output logic [PWR_W-1:0] acc_mag_o,
   output logic             irms_vld_o,
   output logic [PWR_W-1:0] irms_mag_o,
   output logic             nl_flag_o,
   output logic             irq_o
);
   logic [PWR_W-1:0] thr;
   logic             det_en;
   logic             pwr_below;
   logic             irms_below;

   nlc_thresh_sel #(.PWR_W(PWR_W), .FULL_SCALE(FULL_SCALE)) u_thr (
      .mode_i   (nl_mode_i),
      .thr_o    (thr),
      .det_en_o (det_en)
   );

   nlc_gate #(.PWR_W(PWR_W), .DROP_STYLE(DROP_STYLE)) u_pwr_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (smp_vld_i),
      .mag_i    (smp_mag_i),
      .thr_i    (thr),
      .det_en_i (det_en),
      .vld_o    (acc_vld_o),
      .mag_o    (acc_mag_o),
      .below_o  (pwr_below)
   );

   nlc_gate #(.PWR_W(PWR_W), .DROP_STYLE(DROP_STYLE)) u_irms_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (irms_vld_i),
      .mag_i    (irms_mag_i),
      .thr_i    (thr),
      .det_en_i (det_en && irms_sel_i),
      .vld_o    (irms_vld_o),
      .mag_o    (irms_mag_o),
      .below_o  (irms_below)
   );

   nlc_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (pwr_below),
      .clr_i    (stat_clr_i),
      .irq_en_i (irq_en_i),
      .flag_o   (nl_flag_o),
      .irq_o    (irq_o)
   );

   assert_irms_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irms_below && !pwr_below && !stat_clr_i) |=> $stable(nl_flag_o));

   assert_off_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (nl_mode_i == 2'b00 && !stat_clr_i) |=> $stable(nl_flag_o));
endmodule

// File: tb/tb_nlc_detector.sv
module tb_nlc_detector;
   localparam int              PWR_W = 24;
   localparam longint unsigned FS    = 64'd8000000;
   localparam longint unsigned T1    = (FS * 3) / 10000;
   localparam longint unsigned T2    = T1 / 2;
   localparam longint unsigned T3    = T1 / 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             smp_vld_i, irq_en_i, stat_clr_i, irms_sel_i, irms_vld_i;
   logic [PWR_W-1:0] smp_mag_i, irms_mag_i;
   logic [1:0]       nl_mode_i;
   logic             acc_vld_o, irms_vld_o, nl_flag_o, irq_o;
   logic [PWR_W-1:0] acc_mag_o, irms_mag_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   nlc_detector #(.PWR_W(PWR_W), .FULL_SCALE(FS)) dut (
      .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_mag_i(smp_mag_i),
      .nl_mode_i(nl_mode_i), .irq_en_i(irq_en_i), .stat_clr_i(stat_clr_i),
      .irms_sel_i(irms_sel_i), .irms_vld_i(irms_vld_i), .irms_mag_i(irms_mag_i),
      .acc_vld_o(acc_vld_o), .acc_mag_o(acc_mag_o), .irms_vld_o(irms_vld_o),
      .irms_mag_o(irms_mag_o), .nl_flag_o(nl_flag_o), .irq_o(irq_o)
   );

   // Vector fields: mode(2) | magnitude(24) | expected magnitude(24) | expected flag(1)
   localparam int NV = 11;
   localparam logic [50:0] VEC [NV] = '{
      {2'd0, 24'(5),      24'(5),      1'b0},  // R1
      {2'd0, 24'(0),      24'(0),      1'b0},  // R1
      {2'd1, 24'(T1 - 1), 24'(0),      1'b1},  // R2 R3
      {2'd1, 24'(T1),     24'(T1),     1'b0},  // R4
      {2'd2, 24'(T2 - 1), 24'(0),      1'b1},  // R2
      {2'd2, 24'(T2),     24'(T2),     1'b0},  // R4
      {2'd3, 24'(T3 - 1), 24'(0),      1'b1},  // R2
      {2'd3, 24'(T3),     24'(T3),     1'b0},  // R4
      {2'd3, 24'(1000),   24'(1000),   1'b0},  // R2
      {2'd1, 24'(1000),   24'(0),      1'b1},  // R3
      {2'd2, 24'(0),      24'(0),      1'b1}   // R3
   };

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; smp_vld_i = 0; smp_mag_i = '0; nl_mode_i = 2'd0;
      irq_en_i = 0; stat_clr_i = 0; irms_sel_i = 0; irms_vld_i = 0; irms_mag_i = '0;
      repeat (3) @(negedge clk);
      check("R10 acc_vld in reset", acc_vld_o, 0);
      check("R10 flag in reset", nl_flag_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 acc_vld after reset", acc_vld_o, 0);
      check("R10 acc_mag after reset", acc_mag_o, 0);
      check("R10 irms_vld after reset", irms_vld_o, 0);
      check("R10 irq after reset", irq_o, 0);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         nl_mode_i = VEC[i][50:49];
         smp_mag_i = VEC[i][48:25];
         smp_vld_i = 1'b1;
         @(negedge clk);
         smp_vld_i = 1'b0;
         check("R3 vector acc_vld", acc_vld_o, 1);
         check("R1 R3 R4 vector acc_mag", acc_mag_o, VEC[i][24:1]);
         check("R5 vector flag", nl_flag_o, VEC[i][0]);
         stat_clr_i = 1'b1;
         @(negedge clk);
         stat_clr_i = 1'b0;
         check("R6 flag cleared", nl_flag_o, 0);
         check("R10 idle acc_vld", acc_vld_o, 0);
      end

      // R5 sticky: set, then idle cycles keep it
      nl_mode_i = 2'd1; smp_mag_i = 24'd10; smp_vld_i = 1'b1;
      @(negedge clk);
      smp_vld_i = 1'b0; nl_mode_i = 2'd0;
      repeat (3) @(negedge clk);
      check("R5 flag sticky", nl_flag_o, 1);

      // R7 interrupt qualification
      check("R7 irq disabled", irq_o, 0);
      irq_en_i = 1'b1;
      #1;
      check("R7 irq enabled", irq_o, 1);
      stat_clr_i = 1'b1;
      @(negedge clk);
      stat_clr_i = 1'b0;
      check("R7 irq after clear", irq_o, 0);

      // R6 simultaneous set and clear
      nl_mode_i = 2'd3; smp_mag_i = 24'd5; smp_vld_i = 1'b1; stat_clr_i = 1'b1;
      @(negedge clk);
      smp_vld_i = 1'b0; stat_clr_i = 1'b0;
      check("R6 set wins over clear", nl_flag_o, 1);
      check("R7 irq raised", irq_o, 1);
      stat_clr_i = 1'b1;
      @(negedge clk);
      stat_clr_i = 1'b0;
      check("R6 clear alone", nl_flag_o, 0);
      irq_en_i = 1'b0;

      // R9 back-to-back samples with a mode change
      smp_vld_i = 1'b1; smp_mag_i = 24'd1000; nl_mode_i = 2'd1;
      @(negedge clk);
      nl_mode_i = 2'd3;
      check("R9 first sample blocked", acc_mag_o, 0);
      @(negedge clk);
      nl_mode_i = 2'd0; smp_mag_i = 24'd3;
      check("R9 second sample passed", acc_mag_o, 1000);
      @(negedge clk);
      smp_vld_i = 1'b0;
      check("R9 disabled third sample", acc_mag_o, 3);
      stat_clr_i = 1'b1;
      @(negedge clk);
      stat_clr_i = 1'b0;

      // R8 RMS path
      irms_vld_i = 1'b1; irms_mag_i = 24'd100; nl_mode_i = 2'd1; irms_sel_i = 1'b1;
      @(negedge clk);
      check("R8 rms blocked vld", irms_vld_o, 1);
      check("R8 rms blocked mag", irms_mag_o, 0);
      check("R8 rms no flag", nl_flag_o, 0);
      irms_sel_i = 1'b0;
      @(negedge clk);
      check("R8 rms unselected", irms_mag_o, 100);
      irms_sel_i = 1'b1; nl_mode_i = 2'd0;
      @(negedge clk);
      check("R8 rms mode off", irms_mag_o, 100);
      irms_mag_i = 24'(T1); nl_mode_i = 2'd1;
      @(negedge clk);
      irms_vld_i = 1'b0;
      check("R8 R4 rms at threshold", irms_mag_o, T1);
      @(negedge clk);
      check("R10 rms idle", irms_vld_o, 0);
      check("R8 flag untouched", nl_flag_o, 0);

      finish_run();
   end
endmodule